// File: doc/BRIEF.md
# Double-Buffered Stream Buffer with Reorder Fill

This block sits between a wide, banked register file and a narrower client. It holds two halves of `HALF` words each (64 words in all by default). A whole half moves to or from the register file in one cycle over a block-wide port. The client side moves `CW` words per beat. A cluster-style client uses 8 words per beat and a narrow client uses 1. While one half is being drained or filled by the client, the other half can be exchanged with the register file, so the two sides overlap.

The operating mode is chosen on `mode_i` and is changed only while the buffer is empty, for example just after reset. Mode 0 is read-stream: the register file fills halves and the client drains them. Mode 1 is write-stream: the client fills halves, and each full half is flushed to the register file. Mode 2 is reorder-load: words arrive in any order on an indexed fill port, each word goes to the slot its index names, and a half is handed to the register file once every slot in it holds data. Mode 3 is off.

Inside a block, word `i` occupies bits `[i*W +: W]` of the block bus. A block-wide address can therefore be taken apart as (bank, word-in-bank) by whoever drives the bus, and this block does not care which way that is done.

Top module: `sbuf_stream_buffer`

## Requirements
- R1: After reset, both halves are empty. In mode 0 `rf_req_o`=1 and `cl_ready_o`=0. In mode 1 `cl_ready_o`=1 and `rf_req_o`=0. In mode 2 both are 0.
- R2: In mode 0, a cycle with `rf_req_o` and `rf_gnt_i` both high loads the whole half from `rf_rdata_i` at that clock edge. From the next cycle, `cl_ready_o` is 1, and beat `g` of a half presents words `g*CW .. g*CW+CW-1` on `cl_rdata_o`, with word `g*CW+j` in lane `j`.
- R3: In mode 0, `cl_ready_o` is 0 whenever both halves are empty, and a client request then transfers nothing.
- R4: In mode 0, the register file may fill the second half while the first is still held. `rf_req_o` drops when both halves are full. The client drains halves in the order they were filled. A half becomes empty again after its last beat, and `rf_req_o` then rises.
- R5: In mode 1, each accepted beat writes `CW` words into the current half in ascending order. In the cycle after the beat that writes the half's last word, `rf_req_o` is 1 and `rf_wdata_o` carries all of that half's words.
- R6: In mode 1, `cl_ready_o` is 0 while both halves are full and waiting for a flush. A beat offered then is neither stored nor counted.
- R7: In modes 1 and 2, `rf_req_o` stays high until it is granted. Halves are flushed in the order they completed, and the next pending half appears on `rf_wdata_o` in the cycle after a grant.
- R8: In mode 2, a fill word with 6-bit index `i` is stored in slot `i`: bit 5 selects the half and bits 4:0 select the slot within it. The arrival order does not matter.
- R9: In mode 2, a half is offered to the register file only when all of its slots are valid. Halves are released low half first, then high half, in alternation, even if the high half completes first.
- R10: In mode 2, a fill to a slot that is already valid is ignored. All valid marks of a half are cleared when the half is released, so that half can be filled again.
- R11: `cl_ready_o` is 0 in mode 2. In mode 3, `rf_req_o` and `cl_ready_o` are 0, and grants, client beats and fills change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 read-stream, 1 write-stream, 2 reorder-load, 3 off |
| rf_req_o | output | 1 | Block transfer wanted (fill in mode 0, flush in modes 1 and 2) |
| rf_gnt_i | input | 1 | Block transfer happens this cycle |
| rf_rdata_i | input | HALF*W | Block from the register file |
| rf_wdata_o | output | HALF*W | Block to the register file (oldest pending half) |
| cl_valid_i | input | 1 | Client offers a beat |
| cl_ready_o | output | 1 | Buffer can take or give a beat |
| cl_wdata_i | input | CW*W | Client write beat |
| cl_rdata_o | output | CW*W | Client read beat |
| fill_valid_i | input | 1 | Indexed fill word present |
| fill_idx_i | input | log2(2*HALF) | Slot index of the fill word |
| fill_data_i | input | W | Fill word |

## Verification
A wrong half pointer or a lost full flag shows up in the first cycle after the event. A block is then offered twice or skipped, or `cl_ready_o` stays high over an empty half. A beat counter that slips by one, whether on a stalled beat or at a half boundary, misaligns every later word in that half. The next flush or drain exposes this with all the words in the wrong lanes. A valid mark that is never set, or never cleared, shows as a release that never comes or one that comes a half too early. The bench detects this by sampling `rf_req_o` right before and right after the last slot is filled, and again after each grant.

// File: rtl/sbuf_pkg.sv
// Shared definitions for the double-buffered stream buffer.
package sbuf_pkg;
    // Operating modes selected on mode_i.
    typedef enum logic [1:0] {
        SB_RD  = 2'd0,
        SB_WR  = 2'd1,
        SB_RO  = 2'd2,
        SB_OFF = 2'd3
    } sb_mode_e;
endpackage

// File: rtl/sbuf_store.sv
// Word storage for both halves.
// Three write paths: a whole half (block), one client beat (group) and one
// indexed slot. Two read paths: a client beat and a whole half.
// Assumes at most one write path is active per cycle (the mode decides which).
module sbuf_store #(
    parameter int W    = 32,
    parameter int HALF = 32,
    parameter int CW   = 8
) (
    input  logic                          clk,
    input  logic                          blk_we,
    input  logic                          blk_half,
    input  logic [HALF*W-1:0]             blk_wdata,
    input  logic                          grp_we,
    input  logic                          grp_half,
    input  logic [((HALF/CW)>1 ? $clog2(HALF/CW) : 1)-1:0] grp_off,
    input  logic [CW*W-1:0]               grp_wdata,
    input  logic                          slot_we,
    input  logic [$clog2(2*HALF)-1:0]     slot_idx,
    input  logic [W-1:0]                  slot_wdata,
    input  logic                          rd_half,
    input  logic [((HALF/CW)>1 ? $clog2(HALF/CW) : 1)-1:0] rd_off,
    output logic [CW*W-1:0]               grp_rdata,
    input  logic                          fl_half,
    output logic [HALF*W-1:0]             blk_rdata
);
    localparam int DEPTH = 2 * HALF;
    localparam int IW    = $clog2(DEPTH);
    localparam int GRP   = HALF / CW;
    localparam int GW    = (GRP > 1) ? $clog2(GRP) : 1;

    logic [W-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        localparam int H = s / HALF;
        localparam int O = s % HALF;
        localparam int G = O / CW;
        localparam int L = O % CW;
        logic [W-1:0] q;
        // Capture one word from whichever path targets this slot.
        always_ff @(posedge clk) begin
            if (blk_we && blk_half == 1'(H))
                q <= blk_wdata[O*W +: W];
            else if (grp_we && grp_half == 1'(H) && grp_off == GW'(G))
                q <= grp_wdata[L*W +: W];
            else if (slot_we && slot_idx == IW'(s))
                q <= slot_wdata;
        end
        assign slot_q[s] = q;
    end

    logic [IW-1:0] rd_base;
    logic [IW-1:0] fl_base;
    assign rd_base = IW'(rd_half) * IW'(HALF) + IW'(rd_off) * IW'(CW);
    assign fl_base = IW'(fl_half) * IW'(HALF);

    // Present one client beat from the selected half and offset.
    always_comb begin
        for (int j = 0; j < CW; j++)
            grp_rdata[j*W +: W] = slot_q[rd_base + IW'(j)];
    end

    // Present the whole selected half for a flush.
    always_comb begin
        for (int i = 0; i < HALF; i++)
            blk_rdata[i*W +: W] = slot_q[fl_base + IW'(i)];
    end
endmodule

// File: rtl/sbuf_pingpong.sv
// Ping-pong bookkeeping for two halves: a full flag per half, a producer
// pointer and a consumer pointer. Producer and consumer each finish halves
// strictly in alternation. Assumes prod_done only arrives for an empty half.
module sbuf_pingpong (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prod_done,
    input  logic       cons_done,
    output logic [1:0] full,
    output logic       prod_ptr,
    output logic       cons_ptr
);
    logic [1:0] full_nxt;

    // Next full flags: clear on consume, set on produce.
    always_comb begin
        for (int h = 0; h < 2; h++)
            full_nxt[h] = (full[h] && !(cons_done && cons_ptr == 1'(h)))
                          || (prod_done && prod_ptr == 1'(h));
    end

    // Advance pointers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 2'b00;
            prod_ptr <= 1'b0;
            cons_ptr <= 1'b0;
        end else begin
            full <= full_nxt;
            if (prod_done) prod_ptr <= ~prod_ptr;
            if (cons_done) cons_ptr <= ~cons_ptr;
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_done |-> !full[prod_ptr]);
    // R4
    fill_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_done && !cons_done) |=> full[$past(prod_ptr)]);
endmodule

// File: rtl/sbuf_slotvalid.sv
// Per-slot valid marks for reorder-load mode and a per-half completion flag.
// A set is assumed pre-filtered so it only targets an invalid slot; a clear
// wipes every mark of one half at once.
module sbuf_slotvalid #(
    parameter int HALF = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_we,
    input  logic [$clog2(2*HALF)-1:0] set_idx,
    input  logic                      clr,
    input  logic                      clr_half,
    output logic [2*HALF-1:0]         vld,
    output logic [1:0]                complete
);
    localparam int DEPTH = 2 * HALF;
    localparam int IW    = $clog2(DEPTH);

    // Mark arriving slots, wipe released halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (clr && clr_half == 1'(s / HALF))
                    vld[s] <= 1'b0;
                else if (set_we && set_idx == IW'(s))
                    vld[s] <= 1'b1;
            end
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign complete[h] = &vld[h*HALF +: HALF];
    end

    // R10
    dup_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |-> !vld[set_idx]);
    // R9
    release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> complete[clr_half]);
    // R10
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !clr_half) |=> ~|vld[HALF-1:0]);
endmodule

// File: rtl/sbuf_stream_buffer.sv
// Double-buffered stream buffer between a block-wide register-file port and
// a CW-word client port, with an indexed out-of-order fill mode.
// Assumes mode_i changes only while the buffer is empty, and that HALF is a
// multiple of CW.
module sbuf_stream_buffer
    import sbuf_pkg::*;
#(
    parameter int W    = 32,
    parameter int HALF = 32,
    parameter int CW   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_i,
    output logic                      rf_req_o,
    input  logic                      rf_gnt_i,
    input  logic [HALF*W-1:0]         rf_rdata_i,
    output logic [HALF*W-1:0]         rf_wdata_o,
    input  logic                      cl_valid_i,
    output logic                      cl_ready_o,
    input  logic [CW*W-1:0]           cl_wdata_i,
    output logic [CW*W-1:0]           cl_rdata_o,
    input  logic                      fill_valid_i,
    input  logic [$clog2(2*HALF)-1:0] fill_idx_i,
    input  logic [W-1:0]              fill_data_i
);
    localparam int DEPTH = 2 * HALF;
    localparam int GRP   = HALF / CW;
    localparam int GW    = (GRP > 1) ? $clog2(GRP) : 1;

    sb_mode_e     mode;
    logic [1:0]   full;
    logic         prod_ptr, cons_ptr;
    logic         prod_done, cons_done;
    logic         rf_fire, cl_fire, cl_last;
    logic [GW-1:0] cl_off;
    logic [DEPTH-1:0] vld;
    logic [1:0]   complete;
    logic         slot_we;

    assign mode = sb_mode_e'(mode_i);

    // Handshake and half-completion decode per mode.
    always_comb begin
        rf_req_o   = 1'b0;
        cl_ready_o = 1'b0;
        case (mode)
            SB_RD: begin
                rf_req_o   = !full[prod_ptr];
                cl_ready_o = full[cons_ptr];
            end
            SB_WR: begin
                rf_req_o   = full[cons_ptr];
                cl_ready_o = !full[prod_ptr];
            end
            SB_RO: rf_req_o = complete[cons_ptr];
            default: ;
        endcase
        rf_fire   = rf_req_o && rf_gnt_i;
        cl_fire   = cl_ready_o && cl_valid_i;
        prod_done = (mode == SB_RD) ? rf_fire
                  : (mode == SB_WR) ? (cl_fire && cl_last) : 1'b0;
        cons_done = (mode == SB_RD) ? (cl_fire && cl_last)
                  : (mode == SB_WR || mode == SB_RO) ? rf_fire : 1'b0;
    end

    assign cl_last = (cl_off == GW'(GRP - 1));

    // Client beat offset within the current half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cl_off <= '0;
        else if (cl_fire)
            cl_off <= cl_last ? '0 : cl_off + GW'(1);
    end

    assign slot_we = (mode == SB_RO) && fill_valid_i && !vld[fill_idx_i];

    sbuf_pingpong u_pp (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_done (prod_done),
        .cons_done (cons_done),
        .full      (full),
        .prod_ptr  (prod_ptr),
        .cons_ptr  (cons_ptr)
    );

    sbuf_slotvalid #(.HALF(HALF)) u_vld (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (slot_we),
        .set_idx  (fill_idx_i),
        .clr      ((mode == SB_RO) && rf_fire),
        .clr_half (cons_ptr),
        .vld      (vld),
        .complete (complete)
    );

    sbuf_store #(.W(W), .HALF(HALF), .CW(CW)) u_store (
        .clk        (clk),
        .blk_we     ((mode == SB_RD) && rf_fire),
        .blk_half   (prod_ptr),
        .blk_wdata  (rf_rdata_i),
        .grp_we     ((mode == SB_WR) && cl_fire),
        .grp_half   (prod_ptr),
        .grp_off    (cl_off),
        .grp_wdata  (cl_wdata_i),
        .slot_we    (slot_we),
        .slot_idx   (fill_idx_i),
        .slot_wdata (fill_data_i),
        .rd_half    (cons_ptr),
        .rd_off     (cl_off),
        .grp_rdata  (cl_rdata_o),
        .fl_half    (cons_ptr),
        .blk_rdata  (rf_wdata_o)
    );

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req_o && !rf_gnt_i) |=> (rf_req_o || !$stable(mode_i)));
    // R6
    wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SB_WR && full == 2'b11) |-> !cl_ready_o);
    // R3
    rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SB_RD && full == 2'b00) |-> !cl_ready_o);
endmodule

// File: tb/sbuf_stream_buffer_test.sv
`timescale 1ns/1ps
module sbuf_stream_buffer_test;
    localparam int W = 32, HALF = 32, CW = 8;
    localparam int GRP = HALF / CW;
    localparam int IW = $clog2(2*HALF);

    logic clk = 0, rst_n = 0;
    logic [1:0] mode_i = 2'd0;
    logic rf_req_o, rf_gnt_i = 0;
    logic [HALF*W-1:0] rf_rdata_i = '0, rf_wdata_o;
    logic cl_valid_i = 0, cl_ready_o;
    logic [CW*W-1:0] cl_wdata_i = '0, cl_rdata_o;
    logic fill_valid_i = 0;
    logic [IW-1:0] fill_idx_i = '0;
    logic [W-1:0] fill_data_i = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sbuf_stream_buffer #(.W(W), .HALF(HALF), .CW(CW)) uut (.*);

    function automatic logic [W-1:0] wrd(int seed, int i);
        return {seed[15:0], i[15:0]};
    endfunction
    function automatic logic [HALF*W-1:0] blk(int seed);
        logic [HALF*W-1:0] b;
        for (int i = 0; i < HALF; i++) b[i*W +: W] = wrd(seed, i);
        return b;
    endfunction
    function automatic logic [CW*W-1:0] grp(int seed, int g);
        logic [CW*W-1:0] b;
        for (int j = 0; j < CW; j++) b[j*W +: W] = wrd(seed, g*CW + j);
        return b;
    endfunction

    task automatic chk_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask
    task automatic chk_vec(string req, logic [HALF*W-1:0] act, logic [HALF*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask
    task automatic settle();
        #1;
    endtask

    task automatic do_reset(logic [1:0] m);
        rst_n = 0; mode_i = m; rf_gnt_i = 0; cl_valid_i = 0; fill_valid_i = 0;
        cyc(); cyc();
        rst_n = 1;
        cyc();
    endtask

    // R1: reset state per mode
    task automatic t_reset();
        do_reset(2'd0); settle();
        chk_bit("R1 rd req", rf_req_o, 1'b1);
        chk_bit("R1 rd ready", cl_ready_o, 1'b0);
        do_reset(2'd1); settle();
        chk_bit("R1 wr ready", cl_ready_o, 1'b1);
        chk_bit("R1 wr req", rf_req_o, 1'b0);
        do_reset(2'd2); settle();
        chk_bit("R1 ro req", rf_req_o, 1'b0);
        chk_bit("R1 ro ready", cl_ready_o, 1'b0);
    endtask

    // R2 R3 R4: read-stream ping-pong
    task automatic t_read();
        do_reset(2'd0);
        cl_valid_i = 1; settle();
        chk_bit("R3 empty ready", cl_ready_o, 1'b0);
        cyc();
        cl_valid_i = 0; settle();
        chk_bit("R3 still empty", cl_ready_o, 1'b0);
        rf_gnt_i = 1; rf_rdata_i = blk(1); settle(); cyc();
        rf_rdata_i = blk(2); settle();
        chk_bit("R2 ready after load", cl_ready_o, 1'b1);
        chk_bit("R4 second half req", rf_req_o, 1'b1);
        cyc();
        rf_gnt_i = 0; rf_rdata_i = '0; settle();
        chk_bit("R4 both full no req", rf_req_o, 1'b0);
        for (int g = 0; g < GRP; g++) begin
            cl_valid_i = 1; settle();
            chk_vec("R2 beat A", {{(HALF-CW)*W{1'b0}}, cl_rdata_o}, {{(HALF-CW)*W{1'b0}}, grp(1, g)});
            cyc();
        end
        cl_valid_i = 0; settle();
        chk_bit("R4 refill req", rf_req_o, 1'b1);
        chk_bit("R4 next half ready", cl_ready_o, 1'b1);
        for (int g = 0; g < GRP; g++) begin
            cl_valid_i = 1; settle();
            chk_vec("R4 beat B order", {{(HALF-CW)*W{1'b0}}, cl_rdata_o}, {{(HALF-CW)*W{1'b0}}, grp(2, g)});
            cyc();
        end
        cl_valid_i = 0; settle();
        chk_bit("R3 drained ready", cl_ready_o, 1'b0);
    endtask

    // R5 R6 R7: write-stream with stall
    task automatic t_write();
        do_reset(2'd1);
        for (int g = 0; g < GRP; g++) begin
            cl_valid_i = 1; cl_wdata_i = grp(3, g); settle(); cyc();
        end
        cl_valid_i = 0; settle();
        chk_bit("R5 flush req", rf_req_o, 1'b1);
        chk_vec("R5 flush data", rf_wdata_o, blk(3));
        for (int g = 0; g < GRP; g++) begin
            cl_valid_i = 1; cl_wdata_i = grp(4, g); settle(); cyc();
        end
        cl_wdata_i = grp(9, 0); settle();
        chk_bit("R6 stall", cl_ready_o, 1'b0);
        cyc(); cyc();
        cl_valid_i = 0; settle();
        chk_bit("R7 req held", rf_req_o, 1'b1);
        chk_vec("R7 first half pending", rf_wdata_o, blk(3));
        rf_gnt_i = 1; settle(); cyc();
        rf_gnt_i = 0; settle();
        chk_bit("R7 second req", rf_req_o, 1'b1);
        chk_vec("R7 flush order", rf_wdata_o, blk(4));
        chk_bit("R6 ready after flush", cl_ready_o, 1'b1);
        rf_gnt_i = 1; settle(); cyc();
        rf_gnt_i = 0;
        for (int g = 0; g < GRP; g++) begin
            cl_valid_i = 1; cl_wdata_i = grp(5, g); settle(); cyc();
        end
        cl_valid_i = 0; settle();
        chk_vec("R6 stalled beat dropped", rf_wdata_o, blk(5));
    endtask

    // R8 R9 R10 R11: reorder-load
    task automatic t_reorder();
        do_reset(2'd2);
        cl_valid_i = 1; settle();
        chk_bit("R11 ro no client", cl_ready_o, 1'b0);
        cl_valid_i = 0;
        for (int k = 0; k < HALF; k++) begin
            fill_valid_i = 1; fill_idx_i = IW'(2*HALF-1-k); fill_data_i = wrd(6, HALF-1-k);
            settle(); cyc();
        end
        fill_valid_i = 0; settle();
        chk_bit("R9 high waits for low", rf_req_o, 1'b0);
        for (int k = 0; k < HALF-1; k++) begin
            fill_valid_i = 1; fill_idx_i = IW'((k*7) % HALF); fill_data_i = wrd(7, (k*7) % HALF);
            settle(); cyc();
        end
        fill_idx_i = '0; fill_data_i = 32'hDEAD_BEEF; settle(); cyc();
        fill_valid_i = 0; settle();
        chk_bit("R9 incomplete no req", rf_req_o, 1'b0);
        fill_valid_i = 1; fill_idx_i = IW'((31*7) % HALF); fill_data_i = wrd(7, (31*7) % HALF);
        settle(); cyc();
        fill_valid_i = 0; settle();
        chk_bit("R9 low released", rf_req_o, 1'b1);
        chk_vec("R8 R10 low contents", rf_wdata_o, blk(7));
        rf_gnt_i = 1; settle(); cyc();
        rf_gnt_i = 0; settle();
        chk_bit("R9 high next", rf_req_o, 1'b1);
        chk_vec("R8 high contents", rf_wdata_o, blk(6));
        rf_gnt_i = 1; settle(); cyc();
        rf_gnt_i = 0; settle();
        chk_bit("R10 cleared no req", rf_req_o, 1'b0);
        for (int k = 0; k < HALF; k++) begin
            fill_valid_i = 1; fill_idx_i = IW'(k); fill_data_i = wrd(8, k);
            settle(); cyc();
        end
        fill_valid_i = 0; settle();
        chk_bit("R10 refill req", rf_req_o, 1'b1);
        chk_vec("R10 refill contents", rf_wdata_o, blk(8));
    endtask

    // R11: off mode ignores everything
    task automatic t_off();
        do_reset(2'd3);
        rf_gnt_i = 1; rf_rdata_i = blk(10); cl_valid_i = 1; fill_valid_i = 1;
        fill_idx_i = '0; settle();
        chk_bit("R11 off req", rf_req_o, 1'b0);
        chk_bit("R11 off ready", cl_ready_o, 1'b0);
        cyc(); cyc();
        rf_gnt_i = 0; cl_valid_i = 0; fill_valid_i = 0;
        mode_i = 2'd0; settle();
        chk_bit("R11 off loaded nothing", cl_ready_o, 1'b0);
        chk_bit("R11 off rd req", rf_req_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_read();
        t_write();
        t_reorder();
        t_off();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (R1..): actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule